// File: doc/BRIEF.md
# External Bus Read-Cycle Sequencer

This block generates read accesses on an asynchronous external memory bus. It runs from the timing clock. A request carries a zone number, an address and three phase lengths: lead, active and trail. Each request becomes one bus read cycle. The sequencer drives one chip-select per zone, a read strobe, a write strobe, a read/write direction line and the address bus. It samples the 16-bit data bus in the last cycle of the active phase and returns that word to the requester.

A bus-clock output runs either at the timing-clock rate or at half of it. Every access starts its lead phase in a cycle where the bus clock is high. If a request would start in the low half, one alignment cycle is inserted first. An optional ready input can lengthen the active phase. A configuration bit turns ready sampling on or off.

The request side is a valid/ready handshake:
- `req_ready` is high only while the sequencer is idle.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The request fields are sampled only on that edge, so the requester may change them freely at other times.

The response is a one-cycle `rsp_valid` pulse with `rsp_data`. It has no back-pressure, so the requester must take the word in that cycle.

Top module: `xbrd_top`

## Requirements
- R1: A taken request runs lead, active and trail phases in that order. Each phase lasts max(1, programmed count) timing-clock cycles, plus any ready stretch in the active phase.
- R2: The first lead cycle always has `bus_clk` high. If the cycle after acceptance would have `bus_clk` low, exactly one alignment cycle comes before the lead phase; otherwise there is none.
- R3: During alignment cycles, all chip-selects and the read strobe are high (inactive).
- R4: Outside lead, active and trail, including alignment cycles, `bus_addr` keeps the last address driven. It is 0 after reset. It shows the request address for the whole access.
- R5: With `cfg_half_rate`=0, `bus_clk` is constantly 1, so every timing cycle starts a bus period. With `cfg_half_rate`=1, `bus_clk` toggles every timing cycle.
- R6: `bus_cs_n[z]` is low for every lead, active and trail cycle of an access to zone z. All other chip-selects stay high.
- R7: `bus_rd_n` is low exactly during the active phase cycles.
- R8: `rsp_data` equals the value on `bus_din` in the last active cycle, the last cycle in which `bus_rd_n` is low.
- R9: `bus_we_n` is 1 and `bus_rnw` is 1 (read) at all times.
- R10: With `cfg_use_ready`=1, the active phase continues past its count while `bus_ready` is sampled low in its final cycle. It ends after the first such cycle with `bus_ready` high.
- R11: With `cfg_use_ready`=0, `bus_ready` has no effect on phase lengths.
- R12: `rsp_valid` is high for exactly one cycle, in the cycle right after the last trail cycle. `req_ready` is low from acceptance until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_rate | input | 1 | 1: bus clock at half the timing clock rate |
| cfg_use_ready | input | 1 | 1: bus_ready stretches the active phase |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_zone | input | ZW | Zone number selecting the chip-select |
| req_addr | input | AW | Read address |
| req_lead | input | CW | Lead phase cycles (0 treated as 1) |
| req_active | input | CW | Active phase cycles (0 treated as 1) |
| req_trail | input | CW | Trail phase cycles (0 treated as 1) |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | DW | Captured read word |
| bus_clk | output | 1 | Divided bus clock |
| bus_cs_n | output | NZ | Per-zone chip-selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low (always inactive) |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_addr | output | AW | Address bus |
| bus_din | input | DW | External data bus |
| bus_ready | input | 1 | External ready |

## Verification
The bench builds the block with NZ=4, AW=8, DW=16 and CW=3. This makes every phase count from 0 to 3 reachable, and a full sweep of lead × active × trail values fits in a short run. For each count triple, it uses both bus-clock rates and three ready modes: ignored while toggling, enabled with no stretch, and enabled with a two-cycle stretch. Idle gaps of zero and one cycle move each request to both phases of the half-rate bus clock, so both the aligned and the misaligned start are covered at every point of the sweep.

// File: rtl/xbrd_pkg.sv
package xbrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_LEAD  = 3'd2,
    ST_ACT   = 3'd3,
    ST_TRAIL = 3'd4
  } xbrd_state_e;
endpackage

// File: rtl/xbrd_clkdiv.sv
module xbrd_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic bus_clk,
  output logic next_low
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign bus_clk  = half_rate ? ph_q : 1'b1;
  // the next cycle has bus_clk low only at half rate when ph is now high
  assign next_low = half_rate & ph_q;

  // R5
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && $past(half_rate) && $past(rst_n)) |-> (bus_clk != $past(bus_clk)));
endmodule

// File: rtl/xbrd_fsm.sv
module xbrd_fsm
  import xbrd_pkg::*;
#(
  parameter int NZ = 8,
  parameter int AW = 19,
  parameter int CW = 4,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_ready,
  input  logic          next_low,
  input  logic          bus_clk,
  input  logic          bus_ready,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [ZW-1:0] req_zone,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_lead,
  input  logic [CW-1:0] req_active,
  input  logic [CW-1:0] req_trail,
  output xbrd_state_e   state,
  output logic [ZW-1:0] zone,
  output logic [AW-1:0] addr,
  output logic          capture,
  output logic          done
);
  xbrd_state_e   st_q;
  logic [CW-1:0] cnt_q, act_q, trl_q;
  logic [AW-1:0] lat_addr_q, addr_q;
  logic [ZW-1:0] zone_q;
  logic          done_q;
  logic          take, cnt_zero, act_end;

  function automatic logic [CW-1:0] load_val(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign take     = (st_q == ST_IDLE) && req_valid;
  assign cnt_zero = (cnt_q == '0);
  assign act_end  = (st_q == ST_ACT) && cnt_zero && (!use_ready || bus_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      act_q      <= '0;
      trl_q      <= '0;
      lat_addr_q <= '0;
      addr_q     <= '0;
      zone_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (st_q == ST_TRAIL) && cnt_zero;
      unique case (st_q)
        ST_IDLE: if (take) begin
          zone_q     <= req_zone;
          lat_addr_q <= req_addr;
          act_q      <= load_val(req_active);
          trl_q      <= load_val(req_trail);
          cnt_q      <= load_val(req_lead);
          if (next_low) st_q <= ST_ALIGN;
          else begin
            st_q   <= ST_LEAD;
            addr_q <= req_addr;
          end
        end
        ST_ALIGN: begin
          st_q   <= ST_LEAD;
          addr_q <= lat_addr_q;
        end
        ST_LEAD: begin
          if (cnt_zero) begin
            st_q  <= ST_ACT;
            cnt_q <= act_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ACT: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (act_end) begin
            st_q  <= ST_TRAIL;
            cnt_q <= trl_q;
          end
        end
        ST_TRAIL: begin
          if (cnt_zero) st_q <= ST_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign state     = st_q;
  assign zone      = zone_q;
  assign addr      = addr_q;
  assign capture   = act_end;
  assign done      = done_q;

  // R2
  lead_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD && $past(st_q) != ST_LEAD && $past(rst_n)) |-> bus_clk);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (st_q == ST_IDLE || st_q == ST_ALIGN)) |-> $stable(addr_q));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/xbrd_pins.sv
module xbrd_pins
  import xbrd_pkg::*;
#(
  parameter int NZ = 8,
  parameter int DW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xbrd_state_e   state,
  input  logic [ZW-1:0] zone,
  input  logic          capture,
  input  logic [DW-1:0] bus_din,
  output logic [NZ-1:0] cs_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          rnw,
  output logic [DW-1:0] data
);
  logic          in_access;
  logic [DW-1:0] data_q;

  assign in_access = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_TRAIL);

  for (genvar z = 0; z < NZ; z++) begin : g_cs
    assign cs_n[z] = !(in_access && (zone == ZW'(z)));
  end

  assign rd_n = (state != ST_ACT);
  assign we_n = 1'b1;
  assign rnw  = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= bus_din;
  end
  assign data = data_q;

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R7
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (cs_n != '1));
  // R3
  align_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGN) |-> (rd_n && cs_n == '1));
endmodule

// File: rtl/xbrd_top.sv
module xbrd_top
  import xbrd_pkg::*;
#(
  parameter int NZ = 8,
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int CW = 4,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_half_rate,
  input  logic          cfg_use_ready,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [ZW-1:0] req_zone,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_lead,
  input  logic [CW-1:0] req_active,
  input  logic [CW-1:0] req_trail,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_clk,
  output logic [NZ-1:0] bus_cs_n,
  output logic          bus_rd_n,
  output logic          bus_we_n,
  output logic          bus_rnw,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready
);
  xbrd_state_e   state;
  logic [ZW-1:0] zone;
  logic          next_low, capture;

  xbrd_clkdiv u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (cfg_half_rate),
    .bus_clk   (bus_clk),
    .next_low  (next_low)
  );

  xbrd_fsm #(.NZ(NZ), .AW(AW), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_ready  (cfg_use_ready),
    .next_low   (next_low),
    .bus_clk    (bus_clk),
    .bus_ready  (bus_ready),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_zone   (req_zone),
    .req_addr   (req_addr),
    .req_lead   (req_lead),
    .req_active (req_active),
    .req_trail  (req_trail),
    .state      (state),
    .zone       (zone),
    .addr       (bus_addr),
    .capture    (capture),
    .done       (rsp_valid)
  );

  xbrd_pins #(.NZ(NZ), .DW(DW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .zone    (zone),
    .capture (capture),
    .bus_din (bus_din),
    .cs_n    (bus_cs_n),
    .rd_n    (bus_rd_n),
    .we_n    (bus_we_n),
    .rnw     (bus_rnw),
    .data    (rsp_data)
  );

  // R12
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/xbrd_top_test.sv
module xbrd_top_test;
  localparam int NZ = 4, AW = 8, DW = 16, CW = 3, ZW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_half_rate = 1'b0, cfg_use_ready = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ZW-1:0] req_zone = '0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_lead = '0, req_active = '0, req_trail = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic bus_clk, bus_rd_n, bus_we_n, bus_rnw, bus_ready = 1'b0;
  logic [NZ-1:0] bus_cs_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din = '0;

  int checks = 0, fails = 0, acc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xbrd_top #(.NZ(NZ), .AW(AW), .DW(DW), .CW(CW)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (access %0d)", req, act, exp, acc);
    end
  endtask

  task automatic run_access(input int l, input int a, input int t, input bit half,
                            input int mode, input int gap);
    int el, ea, et, s, exp_align, k, cs_cnt, rd_cnt, al_cnt, first_cs;
    int last_din, prev_clk;
    bit zone_ok, ctl_ok, align_ok, clk_ok, addr_ok, busy_ok, order_ok, seen_rd, seen_tr;
    logic [AW-1:0] prev_addr, new_addr;
    logic [ZW-1:0] z;
    el = (l == 0) ? 1 : l;
    ea = (a == 0) ? 1 : a;
    et = (t == 0) ? 1 : t;
    s  = (mode == 2) ? 2 : 0;
    cfg_half_rate = half;
    cfg_use_ready = (mode != 0);
    repeat (gap) @(negedge clk);
    z = ZW'(acc % NZ);
    new_addr = AW'(acc * 13 + 5);
    check(req_ready == 1'b1, "R12 ready when idle", req_ready, 1);
    exp_align = (half && bus_clk) ? 1 : 0;
    prev_addr = bus_addr;
    prev_clk  = bus_clk;
    req_valid = 1'b1; req_zone = z; req_addr = new_addr;
    req_lead = CW'(l); req_active = CW'(a); req_trail = CW'(t);
    @(negedge clk);
    req_valid = 1'b0; req_addr = '1;
    check(rsp_valid == 1'b0, "R12 single pulse", rsp_valid, 0);
    k = 1; cs_cnt = 0; rd_cnt = 0; al_cnt = 0; first_cs = 0; last_din = -1;
    zone_ok = 1; ctl_ok = 1; align_ok = 1; clk_ok = 1; addr_ok = 1; busy_ok = 1;
    order_ok = 1; seen_rd = 0; seen_tr = 0;
    while (!rsp_valid && k < 60) begin
      if (half) begin if (bus_clk == prev_clk) clk_ok = 0; end
      else if (bus_clk != 1'b1) clk_ok = 0;
      prev_clk = bus_clk;
      if (bus_we_n !== 1'b1 || bus_rnw !== 1'b1) ctl_ok = 0;
      if (req_ready) busy_ok = 0;
      if (bus_cs_n == '1) begin
        if (cs_cnt == 0) begin
          al_cnt++;
          if (!bus_rd_n || bus_addr != prev_addr) align_ok = 0;
        end else order_ok = 0;
      end else begin
        if (cs_cnt == 0) begin
          first_cs = k;
          if (!bus_clk) clk_ok = 0;
        end
        cs_cnt++;
        if (bus_cs_n != ~(NZ'(1) << z)) zone_ok = 0;
        if (bus_addr != new_addr) addr_ok = 0;
        if (!bus_rd_n) begin
          if (seen_tr) order_ok = 0;
          seen_rd = 1;
        end else if (seen_rd) seen_tr = 1;
      end
      if (!bus_rd_n) rd_cnt++;
      bus_din = DW'(k * 37 + acc * 101);
      if (!bus_rd_n) last_din = int'(bus_din);
      if (mode == 0)      bus_ready = k[0];
      else if (mode == 1) bus_ready = 1'b1;
      else                bus_ready = (rd_cnt >= ea + s);
      @(negedge clk);
      k++;
    end
    check(k == exp_align + el + ea + s + et + 1, "R1 access latency", k,
          exp_align + el + ea + s + et + 1);
    check(al_cnt == exp_align, "R2 alignment count", al_cnt, exp_align);
    check(clk_ok, "R5/R2 bus clock pattern and lead start", clk_ok, 1);
    check(align_ok, "R3/R4 alignment idle with held address", align_ok, 1);
    check(addr_ok, "R4 address during access", addr_ok, 1);
    check(zone_ok && cs_cnt == el + ea + s + et, "R6 chip-select span", cs_cnt, el + ea + s + et);
    check(rd_cnt == ea + s && order_ok && first_cs == exp_align + 1, "R7 read strobe span", rd_cnt, ea + s);
    check(int'(rsp_data) == last_din, "R8 captured word", rsp_data, last_din);
    check(ctl_ok, "R9 write strobe and direction", ctl_ok, 1);
    if (mode == 2) check(rd_cnt == ea + 2, "R10 ready stretch", rd_cnt, ea + 2);
    if (mode == 0) check(rd_cnt == ea, "R11 ready ignored", rd_cnt, ea);
    check(busy_ok && rsp_valid, "R12 busy during access and done pulse", busy_ok, 1);
    acc++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == '1 && bus_rd_n == 1'b1, "R3 reset controls inactive", bus_cs_n, 15);
    check(bus_addr == '0, "R4 reset address", bus_addr, 0);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 reset handshake", rsp_valid, 0);
    check(bus_we_n == 1'b1 && bus_rnw == 1'b1, "R9 reset direction", bus_we_n, 1);
    for (int h = 0; h < 2; h++)
      for (int m = 0; m < 3; m++)
        for (int g = 0; g < 2; g++)
          for (int l = 0; l < 4; l++)
            for (int a = 0; a < 4; a++)
              for (int t = 0; t < 4; t++)
                run_access(l, a, t, h[0], m, g);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule